// File: doc/BRIEF.md
# Byte Permutation Unit for 4x4 Byte Matrices

This block reorders the bytes of a 128-bit word without changing any byte value. The word is treated as sixteen bytes. The same bytes can also be read as a 4x4 matrix with four 32-bit rows. A two-bit mode input picks one of four reorderings:

- a diagonal skew that prepares an input matrix,
- the matching unskew that recovers a result matrix,
- a one-byte rotation inside each 32-bit row,
- a rotation of the whole word by a multiple of the row width.

A compute datapath uses these reorderings around an accumulate loop. Each multiply step then works on a full word instead of one aligned row.

Every output byte is copied from exactly one input byte, and no byte is copied twice. The result is captured in an output register when `in_valid` is high. `out_valid` goes high one cycle after the accepted input.

Top module: `vperm_unit`

## Requirements
- R1: Byte b of the word occupies bits [8b+7:8b], with byte 0 the least significant. Matrix element [x][y] is byte 4x+y, so row x occupies bytes 4x..4x+3. With mode 0 (skew), output element [x][y] is input element [(x+y) mod 4][x].
- R2: With mode 1 (unskew), output element [x][y] is input element [x][(x+y) mod 4].
- R3: With mode 2 (row rotate), each 32-bit row rotates by one byte toward higher byte index. Output byte 4r+((c+1) mod 4) is input byte 4r+c.
- R4: With mode 3 (vector rotate), the 128-bit word rotates toward higher byte index by 4*step bytes, where step is 2 bits. Output byte (b+4*step) mod 16 is input byte b, and step 0 returns the word unchanged.
- R5: In every mode, each output byte comes from a distinct input byte, so the multiset of byte values and the number of set bits are preserved.
- R6: `out_valid` equals `in_valid` delayed by exactly one clock. The permuted data of an accepted word appears on `out_data` in that same cycle, including for back-to-back words.
- R7: While `in_valid` is low, `out_data` keeps its last value whatever the other inputs do.
- R8: `in_step` has no effect in modes 0, 1 and 2.
- R9: While `rst_n` is low (asynchronous, active low), `out_valid` is 0 and `out_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid and is captured this cycle |
| in_mode | input | 2 | 0 skew, 1 unskew, 2 row rotate, 3 vector rotate |
| in_step | input | 2 | Vector rotate step; the amount is 4*step bytes |
| in_data | input | 128 | Input word, byte 0 in the low bits |
| out_valid | output | 1 | Registered output is a new result |
| out_data | output | 128 | Permuted word |

## Verification
An identity pattern, where byte i holds value i, makes every output byte name its own source index. Fixed expected words for this pattern separate the skew from the unskew, the row rotation from the vector rotation, and each of the four rotation steps. Random words are checked against a reference that scatters each source byte to its destination, which is the inverse view of the gather used in the design. Skew followed by unskew is compared with that composed reference and is not assumed to be the identity. Directed cases cover an ignored step in the fixed modes, holding the output while idle, back-to-back words, and reset in the middle of a run.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

  typedef enum logic [1:0] {
    MODE_SKEW   = 2'd0,
    MODE_UNSKEW = 2'd1,
    MODE_ROWROT = 2'd2,
    MODE_VECROT = 2'd3
  } vperm_mode_e;

  // Source byte of destination byte idx; n is the row length in bytes
  function automatic int skew_src(input int idx, input int n);
    int x;
    int y;
    x = idx / n;
    y = idx % n;
    return n * ((x + y) % n) + x;
  endfunction

  function automatic int unskew_src(input int idx, input int n);
    int x;
    int y;
    x = idx / n;
    y = idx % n;
    return n * x + ((x + y) % n);
  endfunction

  function automatic int rowrot_src(input int idx, input int n);
    int r;
    int c;
    r = idx / n;
    c = idx % n;
    return n * r + ((c + n - 1) % n);
  endfunction

  function automatic int vecrot_src(input int idx, input int step, input int n);
    int total;
    total = n * n;
    return (idx + total - n * step) % total;
  endfunction

endpackage

// File: rtl/vperm_fixed.sv
module vperm_fixed #(
  parameter int ROWS   = 4,
  parameter int BYTE_W = 8,
  parameter int KIND   = 0,
  localparam int NBYTES = ROWS * ROWS,
  localparam int VW     = NBYTES * BYTE_W
) (
  input  logic [VW-1:0] din,
  output logic [VW-1:0] dout
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    if (KIND == 0) begin : g_skew
      localparam int SRC = vperm_pkg::skew_src(g, ROWS);
      assign dout[g*BYTE_W +: BYTE_W] = din[SRC*BYTE_W +: BYTE_W];
    end else if (KIND == 1) begin : g_unskew
      localparam int SRC = vperm_pkg::unskew_src(g, ROWS);
      assign dout[g*BYTE_W +: BYTE_W] = din[SRC*BYTE_W +: BYTE_W];
    end else begin : g_rowrot
      localparam int SRC = vperm_pkg::rowrot_src(g, ROWS);
      assign dout[g*BYTE_W +: BYTE_W] = din[SRC*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/vperm_vecrot.sv
module vperm_vecrot #(
  parameter int ROWS   = 4,
  parameter int BYTE_W = 8,
  localparam int NBYTES = ROWS * ROWS,
  localparam int VW     = NBYTES * BYTE_W,
  localparam int SW     = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic [VW-1:0] din,
  input  logic [SW-1:0] step,
  output logic [VW-1:0] dout
);

  logic [VW-1:0] rot_opts [ROWS];

  for (genvar s = 0; s < ROWS; s++) begin : g_step
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      localparam int SRC = vperm_pkg::vecrot_src(g, s, ROWS);
      assign rot_opts[s][g*BYTE_W +: BYTE_W] = din[SRC*BYTE_W +: BYTE_W];
    end
  end

  assign dout = rot_opts[step];

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit #(
  parameter int ROWS   = 4,
  parameter int BYTE_W = 8,
  localparam int NBYTES = ROWS * ROWS,
  localparam int VW     = NBYTES * BYTE_W,
  localparam int SW     = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_mode,
  input  logic [SW-1:0] in_step,
  input  logic [VW-1:0] in_data,
  output logic          out_valid,
  output logic [VW-1:0] out_data
);
  import vperm_pkg::*;

  logic [VW-1:0] skew_w, unskew_w, rowrot_w, vecrot_w, sel_w;
  logic          cap_fire;
  logic          chk_armed;
  vperm_mode_e   mode_w;

  assign mode_w   = vperm_mode_e'(in_mode);
  assign cap_fire = in_valid;

  vperm_fixed #(.ROWS(ROWS), .BYTE_W(BYTE_W), .KIND(0)) u_skew (
    .din(in_data), .dout(skew_w));
  vperm_fixed #(.ROWS(ROWS), .BYTE_W(BYTE_W), .KIND(1)) u_unskew (
    .din(in_data), .dout(unskew_w));
  vperm_fixed #(.ROWS(ROWS), .BYTE_W(BYTE_W), .KIND(2)) u_rowrot (
    .din(in_data), .dout(rowrot_w));
  vperm_vecrot #(.ROWS(ROWS), .BYTE_W(BYTE_W)) u_vecrot (
    .din(in_data), .step(in_step), .dout(vecrot_w));

  always_comb begin
    unique case (mode_w)
      MODE_SKEW:   sel_w = skew_w;
      MODE_UNSKEW: sel_w = unskew_w;
      MODE_ROWROT: sel_w = rowrot_w;
      default:     sel_w = vecrot_w;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= cap_fire;
      if (cap_fire) out_data <= sel_w;
    end
  end

  // Armed once a clock edge has passed outside reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_armed <= 1'b0;
    else        chk_armed <= 1'b1;
  end

  // R6
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed |-> (out_valid == $past(in_valid)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && !$past(in_valid)) |-> $stable(out_data));

  // R5
  no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_valid)) |->
      ($countones(out_data) == $countones($past(in_data))));

  // R4
  vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_valid) && ($past(in_mode) == 2'd3) && ($past(in_step) == '0))
      |-> (out_data == $past(in_data)));

  // R3
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_valid) && ($past(in_mode) == 2'd2))
      |-> (out_data[BYTE_W-1:0] == $past(in_data[ROWS*BYTE_W-1 -: BYTE_W])));

  // R1
  skew_corner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(in_valid) && ($past(in_mode) == 2'd0))
      |-> (out_data[BYTE_W-1:0] == $past(in_data[BYTE_W-1:0])));

endmodule

// File: tb/sim_vperm_unit.sv
`timescale 1ns/1ps
module sim_vperm_unit;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   in_mode = 2'd0;
  logic [1:0]   in_step = 2'd0;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  vperm_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_step(in_step), .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  typedef struct packed {
    logic [1:0]   m;
    logic [1:0]   s;
    logic [127:0] d;
    logic [127:0] e;
  } vec_t;

  localparam logic [127:0] IDP = 128'h0f0e0d0c_0b0a0908_07060504_03020100;

  localparam vec_t TBL [0:8] = '{
    '{2'd0, 2'd0, IDP, 128'h0b07030f_06020e0a_010d0905_0c080400},  // R1
    '{2'd1, 2'd0, IDP, 128'h0e0d0c0f_09080b0a_04070605_03020100},  // R2
    '{2'd2, 2'd0, IDP, 128'h0e0d0c0f_0a09080b_06050407_02010003},  // R3
    '{2'd3, 2'd0, IDP, IDP},                                       // R4 step 0
    '{2'd3, 2'd1, IDP, 128'h0b0a0908_07060504_03020100_0f0e0d0c},  // R4
    '{2'd3, 2'd2, IDP, 128'h07060504_03020100_0f0e0d0c_0b0a0908},  // R4
    '{2'd3, 2'd3, IDP, 128'h03020100_0f0e0d0c_0b0a0908_07060504},  // R4
    '{2'd0, 2'd3, IDP, 128'h0b07030f_06020e0a_010d0905_0c080400},  // R8
    '{2'd2, 2'd2, IDP, 128'h0e0d0c0f_0a09080b_06050407_02010003}   // R8
  };

  localparam string TAGS [0:8] = '{"R1", "R2", "R3", "R4", "R4", "R4", "R4", "R8", "R8"};

  // Scatter reference: each source byte is sent to its destination
  function automatic logic [127:0] ref_perm(input logic [1:0] m, input logic [1:0] s,
                                            input logic [127:0] d);
    logic [127:0] r;
    r = '0;
    for (int src = 0; src < 16; src++) begin
      int p;
      int q;
      int dst;
      p = src / 4;
      q = src % 4;
      case (m)
        2'd0:    dst = 4 * q + ((p - q + 4) % 4);
        2'd1:    dst = 4 * p + ((q - p + 4) % 4);
        2'd2:    dst = 4 * p + ((q + 1) % 4);
        default: dst = (src + 4 * s) % 16;
      endcase
      r[dst*8 +: 8] = d[src*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic [1:0] s, input logic [127:0] d,
                     input logic [127:0] e, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_step = s; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {req, " valid"}, {127'd0, out_valid}, 128'd1);
    check(out_data === e, req, out_data, e);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] hold_v;
    logic [127:0] sk;
    logic [127:0] rnd;
    logic [127:0] ea;
    logic [127:0] eb;

    repeat (3) @(negedge clk);
    // R9 reset state
    check(out_valid === 1'b0, "R9 valid", {127'd0, out_valid}, 128'd0);
    check(out_data === '0, "R9 data", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R6 idle", {127'd0, out_valid}, 128'd0);

    // Table walk on the identity pattern
    for (int i = 0; i <= 8; i++) begin
      run(TBL[i].m, TBL[i].s, TBL[i].d, TBL[i].e, TAGS[i]);
    end

    // Random words against the scatter reference (R1 R2 R3 R4 R5)
    for (int i = 0; i < 40; i++) begin
      logic [1:0] mm;
      logic [1:0] ss;
      rnd = {$urandom, $urandom, $urandom, $urandom};
      mm = 2'(i % 4);
      ss = 2'($urandom % 4);
      run(mm, ss, rnd, ref_perm(mm, ss, rnd), "R5 random");
    end

    // Skew then unskew, compared with the composed reference
    rnd = {$urandom, $urandom, $urandom, $urandom};
    sk = ref_perm(2'd0, 2'd0, rnd);
    run(2'd0, 2'd0, rnd, sk, "R1 chain");
    run(2'd1, 2'd0, out_data, ref_perm(2'd1, 2'd0, sk), "R2 chain");

    // R7 hold while idle, other inputs toggling
    hold_v = out_data;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_data = {$urandom, $urandom, $urandom, $urandom};
      in_mode = 2'(i);
      in_step = 2'(3 - i);
    end
    @(negedge clk);
    check(out_data === hold_v, "R7 hold", out_data, hold_v);
    check(out_valid === 1'b0, "R7 valid low", {127'd0, out_valid}, 128'd0);

    // R6 back-to-back words
    ea = {$urandom, $urandom, $urandom, $urandom};
    eb = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    in_valid = 1'b1; in_mode = 2'd3; in_step = 2'd1; in_data = ea;
    @(negedge clk);
    check(out_valid === 1'b1, "R6 first valid", {127'd0, out_valid}, 128'd1);
    check(out_data === ref_perm(2'd3, 2'd1, ea), "R6 first", out_data, ref_perm(2'd3, 2'd1, ea));
    in_mode = 2'd2; in_data = eb;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R6 second valid", {127'd0, out_valid}, 128'd1);
    check(out_data === ref_perm(2'd2, 2'd0, eb), "R6 second", out_data, ref_perm(2'd2, 2'd0, eb));
    @(negedge clk);
    check(out_valid === 1'b0, "R6 drop", {127'd0, out_valid}, 128'd0);

    // R9 reset mid-run
    run(2'd0, 2'd0, IDP, TBL[0].e, "R1 pre-reset");
    rst_n = 1'b0;
    #1;
    check(out_valid === 1'b0, "R9 mid valid", {127'd0, out_valid}, 128'd0);
    check(out_data === '0, "R9 mid data", out_data, '0);
    @(negedge clk);
    rst_n = 1'b1;
    run(2'd1, 2'd0, IDP, TBL[1].e, "R2 post-reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule